// File: doc/BRIEF.md
# Fetch Target Buffer

A small direct-mapped cache of taken branches, read with the fetch address during instruction fetch. When the address of the instruction being fetched matches a stored entry in full, the buffer returns the branch's target as the next fetch address. A taken branch that the buffer knows about therefore costs no fetch bubble. When the address does not match, the next fetch address is the sequential one. Only taken, PC-relative conditional branches are held, so a stored target is a constant for its branch.

Branch resolution reports the branch address, whether the branch was taken, and where it went. The buffer compares that outcome with its own contents. It allocates an entry for a taken branch it did not hold, rewrites an entry whose target was wrong, and drops an entry whose branch fell through. Each of these corrections raises a stall for a fixed number of penalty cycles. The table is written inside that stall window, so it is never written while fetch is reading it.

Top module: `fetch_target_buffer`

## Requirements
- R1: A lookup hits only when the entry at index `lk_pc[ALIGN_W +: IDX_W]` is valid and its stored tag equals `lk_pc[PC_W-1 : ALIGN_W+IDX_W]` in full. On a hit `lk_next` equals the stored target. The lookup is combinational.
- R2: On a lookup miss, `lk_hit` is 0 and `lk_next` equals `lk_pc + 2**ALIGN_W`.
- R3: A resolution that misses and is taken allocates an entry holding that address and its actual target. `stall` is high for `ALLOC_PEN` cycles, starting the cycle after the resolution.
- R4: A resolution that hits, is taken, and has a target equal to the stored one changes nothing and raises no stall.
- R5: A resolution that hits and is taken with a different target rewrites the stored target. `stall` is high for `MISP_PEN` cycles.
- R6: A resolution that hits and is not taken invalidates the entry. `stall` is high for `MISP_PEN` cycles.
- R7: A resolution that misses and is not taken changes nothing and raises no stall.
- R8: While `stall` is high, `lk_hit` is 0 and `lk_next` is sequential. A resolution presented while `stall` is high is ignored.
- R9: After reset every entry is invalid and `stall` is 0.
- R10: The buffer is direct-mapped. An allocation replaces whatever entry held that index, even one with a different tag. A table change becomes visible to lookups once the stall ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | PC_W | Fetch address being looked up |
| lk_hit | output | 1 | Lookup found a taken branch |
| lk_next | output | PC_W | Predicted next fetch address |
| rs_valid | input | 1 | A branch resolution is presented |
| rs_pc | input | PC_W | Address of the resolved branch |
| rs_taken | input | 1 | Actual direction of the branch |
| rs_target | input | PC_W | Actual target of the branch |
| stall | output | 1 | Penalty cycle: fetch must hold |

## Verification
The assertions assume that `rs_valid` reflects one resolution per branch and that the stall output truly holds fetch. They also assume that `lk_pc` and the resolution fields are stable between clock edges. The stimulus drives every input on the falling edge. It keeps resolutions away from the stall window, except for one directed case that deliberately tests R8. Addresses are drawn from a narrow range of tags and indices so that hits, aliasing and retargeting occur often.

// File: rtl/ftb_pkg.sv
package ftb_pkg;
   typedef enum logic [1:0] {
      ACT_NONE     = 2'd0,
      ACT_ALLOC    = 2'd1,
      ACT_RETARGET = 2'd2,
      ACT_DROP     = 2'd3
   } ftb_act_e;
endpackage

// File: rtl/ftb_store.sv
module ftb_store #(
   parameter int PC_W    = 32,
   parameter int IDX_W   = 4,
   parameter int ALIGN_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] rd_pc,
   output logic            rd_hit,
   output logic [PC_W-1:0] rd_target,
   input  logic [PC_W-1:0] chk_pc,
   output logic            chk_hit,
   output logic [PC_W-1:0] chk_target,
   input  logic            wr_en,
   input  logic [PC_W-1:0] wr_pc,
   input  logic            wr_valid,
   input  logic [PC_W-1:0] wr_target
);
   localparam int DEPTH = 1 << IDX_W;
   localparam int TAG_W = PC_W - IDX_W - ALIGN_W;

   logic [DEPTH-1:0] valid_q;
   logic [TAG_W-1:0] tag_q [DEPTH];
   logic [PC_W-1:0]  tgt_q [DEPTH];

   logic [IDX_W-1:0] wr_idx, rd_idx, chk_idx;
   logic [TAG_W-1:0] wr_tag, rd_tag, chk_tag;
   assign wr_idx  = wr_pc[ALIGN_W +: IDX_W];
   assign wr_tag  = wr_pc[PC_W-1 -: TAG_W];
   assign rd_idx  = rd_pc[ALIGN_W +: IDX_W];
   assign rd_tag  = rd_pc[PC_W-1 -: TAG_W];
   assign chk_idx = chk_pc[ALIGN_W +: IDX_W];
   assign chk_tag = chk_pc[PC_W-1 -: TAG_W];

   for (genvar e = 0; e < DEPTH; e++) begin : g_entry
      logic sel;
      assign sel = wr_en && (wr_idx == IDX_W'(e));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            valid_q[e] <= 1'b0;
         end else if (sel) begin
            valid_q[e] <= wr_valid;
         end
      end
      always_ff @(posedge clk) begin
         if (sel && wr_valid) begin
            tag_q[e] <= wr_tag;
            tgt_q[e] <= wr_target;
         end
      end
   end

   assign rd_hit     = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
   assign rd_target  = tgt_q[rd_idx];
   assign chk_hit    = valid_q[chk_idx] && (tag_q[chk_idx] == chk_tag);
   assign chk_target = tgt_q[chk_idx];

   assert_write_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (valid_q[$past(wr_idx)] == $past(wr_valid)));
endmodule

// File: rtl/ftb_resolve.sv
module ftb_resolve
   import ftb_pkg::*;
#(
   parameter int PC_W = 32
) (
   input  logic            rs_valid,
   input  logic            blocked,
   input  logic            rs_taken,
   input  logic [PC_W-1:0] rs_target,
   input  logic            chk_hit,
   input  logic [PC_W-1:0] chk_target,
   output logic            accept,
   output ftb_act_e        act
);
   assign accept = rs_valid && !blocked;

   always_comb begin
      act = ACT_NONE;
      if (accept) begin
         if (chk_hit && !rs_taken)                       act = ACT_DROP;
         else if (chk_hit && (rs_target != chk_target))  act = ACT_RETARGET;
         else if (!chk_hit && rs_taken)                  act = ACT_ALLOC;
      end
   end
endmodule

// File: rtl/ftb_penalty.sv
module ftb_penalty
   import ftb_pkg::*;
#(
   parameter int MISP_PEN  = 2,
   parameter int ALLOC_PEN = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     start,
   input  ftb_act_e act,
   output logic     stall
);
   localparam int MAXP  = (MISP_PEN > ALLOC_PEN) ? MISP_PEN : ALLOC_PEN;
   localparam int CNT_W = $clog2(MAXP + 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (start && act == ACT_ALLOC) begin
         cnt_q <= CNT_W'(ALLOC_PEN);
      end else if (start && act != ACT_NONE) begin
         cnt_q <= CNT_W'(MISP_PEN);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign stall = (cnt_q != '0);

   assert_penalty_starts_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (start && act != ACT_NONE) |=> stall);
   assert_no_penalty_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!stall && !(start && act != ACT_NONE)) |=> !stall);
endmodule

// File: rtl/fetch_target_buffer.sv
module fetch_target_buffer
   import ftb_pkg::*;
#(
   parameter int PC_W      = 32,
   parameter int IDX_W     = 4,
   parameter int ALIGN_W   = 2,
   parameter int MISP_PEN  = 2,
   parameter int ALLOC_PEN = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] lk_pc,
   output logic            lk_hit,
   output logic [PC_W-1:0] lk_next,
   input  logic            rs_valid,
   input  logic [PC_W-1:0] rs_pc,
   input  logic            rs_taken,
   input  logic [PC_W-1:0] rs_target,
   output logic            stall
);
   localparam logic [PC_W-1:0] STEP = PC_W'(1) << ALIGN_W;

   if (MISP_PEN < 1 || ALLOC_PEN < 1) begin : g_bad_pen
      $error("penalty cycles must be at least 1");
   end
   if (PC_W <= IDX_W + ALIGN_W) begin : g_bad_width
      $error("address too narrow for index and alignment");
   end

   logic            rd_hit, chk_hit, accept;
   logic [PC_W-1:0] rd_target, chk_target;
   ftb_act_e        act;

   logic            pend_q;
   logic            pend_valid_q;
   logic [PC_W-1:0] pend_pc_q, pend_tgt_q;

   ftb_store #(.PC_W(PC_W), .IDX_W(IDX_W), .ALIGN_W(ALIGN_W)) i_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_pc      (lk_pc),
      .rd_hit     (rd_hit),
      .rd_target  (rd_target),
      .chk_pc     (rs_pc),
      .chk_hit    (chk_hit),
      .chk_target (chk_target),
      .wr_en      (pend_q),
      .wr_pc      (pend_pc_q),
      .wr_valid   (pend_valid_q),
      .wr_target  (pend_tgt_q)
   );

   ftb_resolve #(.PC_W(PC_W)) i_resolve (
      .rs_valid   (rs_valid),
      .blocked    (stall),
      .rs_taken   (rs_taken),
      .rs_target  (rs_target),
      .chk_hit    (chk_hit),
      .chk_target (chk_target),
      .accept     (accept),
      .act        (act)
   );

   ftb_penalty #(.MISP_PEN(MISP_PEN), .ALLOC_PEN(ALLOC_PEN)) i_penalty (
      .clk   (clk),
      .rst_n (rst_n),
      .start (accept),
      .act   (act),
      .stall (stall)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
      end else begin
         pend_q <= accept && (act != ACT_NONE);
      end
   end

   always_ff @(posedge clk) begin
      if (accept) begin
         pend_pc_q    <= rs_pc;
         pend_tgt_q   <= rs_target;
         pend_valid_q <= (act != ACT_DROP);
      end
   end

   assign lk_hit  = rd_hit && !stall;
   assign lk_next = lk_hit ? rd_target : lk_pc + STEP;

   assert_lookup_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> !lk_hit);
   assert_write_in_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |-> stall);
   assert_stall_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stall) |-> $past(rs_valid));
endmodule

// File: tb/test_fetch_target_buffer.sv
module test_fetch_target_buffer;
   localparam int PC_W = 32, IDX_W = 4, ALIGN_W = 2, MISP_PEN = 2, ALLOC_PEN = 2;
   localparam int DEPTH = 1 << IDX_W;
   localparam int TAG_W = PC_W - IDX_W - ALIGN_W;

   logic clk = 0, rst_n = 0;
   logic [PC_W-1:0] lk_pc = '0, lk_next, rs_pc = '0, rs_target = '0;
   logic lk_hit, rs_valid = 0, rs_taken = 0, stall;
   int total = 0, bad = 0;
   bit done = 0;

   always #5 clk = ~clk;

   fetch_target_buffer #(.PC_W(PC_W), .IDX_W(IDX_W), .ALIGN_W(ALIGN_W),
      .MISP_PEN(MISP_PEN), .ALLOC_PEN(ALLOC_PEN)) i_fetch_target_buffer (
      .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_next(lk_next),
      .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken),
      .rs_target(rs_target), .stall(stall));

   logic             m_v   [DEPTH];
   logic [TAG_W-1:0] m_tag [DEPTH];
   logic [PC_W-1:0]  m_tgt [DEPTH];

   function automatic int idx_of(logic [PC_W-1:0] pc);
      return int'(pc[ALIGN_W +: IDX_W]);
   endfunction
   function automatic logic [TAG_W-1:0] tag_of(logic [PC_W-1:0] pc);
      return pc[PC_W-1 -: TAG_W];
   endfunction
   function automatic bit m_hit(logic [PC_W-1:0] pc);
      return m_v[idx_of(pc)] && m_tag[idx_of(pc)] == tag_of(pc);
   endfunction
   function automatic logic [PC_W-1:0] rand_pc();
      return {2'(($urandom) % 3), 24'h0, 6'(($urandom) & 6'h3C)};
   endfunction

   task automatic chk(bit ok, string req, logic [PC_W-1:0] act, logic [PC_W-1:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic look(logic [PC_W-1:0] pc, string req);
      bit h;
      lk_pc = pc;
      #1;
      h = m_hit(pc);
      chk(lk_hit == h, req, 32'(lk_hit), 32'(h));
      chk(lk_next == (h ? m_tgt[idx_of(pc)] : pc + 4), req, lk_next,
          h ? m_tgt[idx_of(pc)] : pc + 4);
   endtask

   // present one resolution at a negedge and track the penalty window
   task automatic resolve(logic [PC_W-1:0] pc, bit tk, logic [PC_W-1:0] tg, bit poke_in_stall);
      bit h;
      int pen;
      string req;
      h = m_hit(pc);
      if (h && !tk) begin pen = MISP_PEN; req = "R6"; end
      else if (h && tg != m_tgt[idx_of(pc)]) begin pen = MISP_PEN; req = "R5"; end
      else if (h) begin pen = 0; req = "R4"; end
      else if (tk) begin pen = ALLOC_PEN; req = "R3"; end
      else begin pen = 0; req = "R7"; end
      rs_valid = 1; rs_pc = pc; rs_taken = tk; rs_target = tg;
      @(negedge clk);
      rs_valid = 0;
      for (int c = 0; c < pen; c++) begin
         chk(stall == 1'b1, req, 32'(stall), 32'd1);
         lk_pc = pc;
         #1;
         chk(lk_hit == 1'b0 && lk_next == pc + 4, "R8", lk_next, pc + 4);
         if (poke_in_stall && c == 0) begin
            rs_valid = 1; rs_pc = pc ^ 32'h8000_0000; rs_taken = 1; rs_target = 32'h1234;
         end
         @(negedge clk);
         rs_valid = 0;
      end
      chk(stall == 1'b0, req, 32'(stall), 32'd0);
      if (h && !tk) m_v[idx_of(pc)] = 0;
      else if (tk && (!h || tg != m_tgt[idx_of(pc)])) begin
         m_v[idx_of(pc)] = 1; m_tag[idx_of(pc)] = tag_of(pc); m_tgt[idx_of(pc)] = tg;
      end
      look(pc, req);
   endtask

   initial begin
      void'($urandom(32'd2024));
      for (int i = 0; i < DEPTH; i++) begin m_v[i] = 0; m_tag[i] = '0; m_tgt[i] = '0; end
      @(negedge clk); @(negedge clk);
      rst_n = 1;
      // R9: empty after reset
      chk(stall == 1'b0, "R9", 32'(stall), 32'd0);
      for (int i = 0; i < DEPTH; i++) look(32'(i * 4), "R9");
      // R7 then R3, R1
      resolve(32'h0000_0010, 0, 32'h100, 0);
      resolve(32'h0000_0010, 1, 32'h200, 0);
      look(32'h0000_0010, "R1");
      look(32'h4000_0010, "R1");           // same index, other tag: miss (R2)
      look(32'h0000_0014, "R2");
      // R4 same target, R5 new target, R6 drop
      resolve(32'h0000_0010, 1, 32'h200, 0);
      resolve(32'h0000_0010, 1, 32'h300, 0);
      resolve(32'h0000_0010, 0, 32'h300, 0);
      // R10 alias replacement
      resolve(32'h0000_0020, 1, 32'h400, 0);
      resolve(32'h8000_0020, 1, 32'h500, 0);
      look(32'h0000_0020, "R10");
      look(32'h8000_0020, "R10");
      // R8 resolution during stall is ignored
      resolve(32'h0000_0030, 1, 32'h600, 1);
      look(32'h8000_0030, "R8");
      // random mix
      for (int n = 0; n < 600; n++) begin
         logic [PC_W-1:0] p;
         p = rand_pc();
         if ($urandom % 3 == 0) look(p, "R1");
         else if (m_hit(p) && $urandom % 3 == 0) resolve(p, 1, m_tgt[idx_of(p)], 0);
         else resolve(p, 1'($urandom), 32'(($urandom % 4) * 32'h40), 0);
      end
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule